// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block sits next to a floating-point datapath. It holds the floating-point control word, which includes the per-class trap enables. It also keeps a sticky cumulative flag for each of six exception classes: invalid operation, divide-by-zero, overflow, underflow, inexact and input-denormal.

On every cycle with `ev_valid` high, it takes the raw exception events of one operation together with its context bits. The context bits are flush-to-zero active, output flushed, alternate handling, input flushing, another operand NaN, and a denormal input unpacked. From these it forms the effective events.

For each effective event, the block does one of two things. If the class's trap is disabled, or the class is not supported, it sets that class's flag. If the trap is enabled, it leaves the flag alone and requests a trap. The trap request is a one-cycle pulse with a one-hot cause.

A small sequencer produces the pulse. It has two states. `ST_IDLE` is the resting state. `ST_TRAP` is the state in which `trap_req` is high for one cycle.

The transitions are:
- `ST_IDLE` goes to `ST_TRAP` when a trapped event is accepted.
- `ST_TRAP` stays in `ST_TRAP` when another trapped event is accepted in that cycle.
- `ST_TRAP` returns to `ST_IDLE` otherwise.
- `ST_IDLE` stays in `ST_IDLE` otherwise.

Software reads and writes the control word through a plain register port. The status flags have a port of their own, and that port is the only way to clear them.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset, `cw_rdata` is zero, `st_rdata` is zero and `trap_req` is low with `trap_cause` zero.
- R2: A control-word write keeps a fixed set of bits and clears all others. It keeps bits 26:16 and 2:0. It also keeps the trap enables of supported classes at these positions: invalid 8, divide-by-zero 9, overflow 10, underflow 11, inexact 12, input-denormal 15. Every other bit reads zero.
- R3: For a class whose `TRAP_SUPPORT` bit is 0, the enable bit reads zero and ignores writes, and events of that class always set the flag.
- R4: An accepted event of a class whose enable is 0 sets its sticky flag. The flag and cause bit order is: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 input-denormal.
- R5: An accepted event of an enabled class leaves its flag unchanged. `trap_req` is then high for exactly the following cycle, with `trap_cause` one-hot. Back-to-back trapped events give back-to-back pulses.
- R6: When several trapped classes occur in one event, the cause is the lowest-numbered one. Untrapped classes in the same event still set their flags.
- R7: An underflow event with `ctx_ftz` high sets the underflow flag and never traps, even when its enable is 1.
- R8: With `ctx_alt` high, `ctx_flushed` raises an inexact event. With `ctx_alt` low, `ctx_flushed` has no effect.
- R9: With `ctx_alt` high, the input-denormal event is driven by the denormal-unpack input rather than by `ev_raw[5]`. It is raised by `ctx_denorm_in` when `ctx_in_flush` is low. It is suppressed by `ctx_nan_other`, or by a raw invalid or divide-by-zero event in the same operation. With `ctx_alt` low, the event is `ev_raw[5]` and `ctx_denorm_in` is ignored.
- R10: With `ev_valid` low, all event and context inputs are ignored.
- R11: A status write replaces the flags with `st_wdata`. Events accepted in the same cycle are ORed on top. Without a status write, no flag ever clears.
- R12: An event accepted in the same cycle as a control-word write is judged against the enables held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_we | input | 1 | Control word write strobe |
| cw_wdata | input | 64 | Control word write data |
| cw_rdata | output | 64 | Control word read data, non-stored bits zero |
| st_we | input | 1 | Status flag write strobe |
| st_wdata | input | 6 | Status flag write data |
| st_rdata | output | 6 | Sticky status flags |
| ev_valid | input | 1 | Qualifies events and context this cycle |
| ev_raw | input | 6 | Raw events in flag order |
| ctx_ftz | input | 1 | Flush-to-zero active for this operation |
| ctx_flushed | input | 1 | Output was flushed to zero |
| ctx_alt | input | 1 | Alternate handling active |
| ctx_in_flush | input | 1 | Input flushing active |
| ctx_nan_other | input | 1 | Another operand is NaN |
| ctx_denorm_in | input | 1 | A denormal input was unpacked |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 6 | One-hot trap cause, zero when no request |

## Verification
The bench builds the unit with `TRAP_SUPPORT` = 6'b101111, so inexact is the one unsupported class. This makes the read-as-zero enable bit and the forced-untrapped path reachable, including for inexact events created by flushing. The other five enables stay writable. That lets the bench exercise:
- trap priority between classes,
- the underflow exception under flush-to-zero,
- the suppression rules for input-denormal events,
- an input-denormal trap.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NCLS = 6;
    localparam int CW_W = 64;

    // Class index = bit position in flag and cause vectors
    localparam int C_INV = 0;
    localparam int C_DZ  = 1;
    localparam int C_OVF = 2;
    localparam int C_UNF = 3;
    localparam int C_INX = 4;
    localparam int C_IDN = 5;

    // Plain stored fields of the control word: bits 26:16 and 2:0
    localparam logic [CW_W-1:0] CW_PLAIN_MASK = 64'h0000_0000_07FF_0007;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_TRAP = 1'b1} trap_st_e;

    // Control-word bit holding the trap enable of a class
    function automatic int en_pos(int c);
        case (c)
            0:       return 8;
            1:       return 9;
            2:       return 10;
            3:       return 11;
            4:       return 12;
            default: return 15;
        endcase
    endfunction

    function automatic logic [CW_W-1:0] en_mask(logic [NCLS-1:0] sup);
        logic [CW_W-1:0] m;
        m = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (sup[c]) m[en_pos(c)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
    import fpx_pkg::*;
#(
    parameter logic [NCLS-1:0] TRAP_SUPPORT = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CW_W-1:0] wdata,
    output logic [CW_W-1:0] cw_q,
    output logic [NCLS-1:0] trap_en
);
    localparam logic [CW_W-1:0] KEEP = CW_PLAIN_MASK | en_mask(TRAP_SUPPORT);

    always_ff @(posedge clk) begin
        if (!rst_n)  cw_q <= '0;
        else if (we) cw_q <= wdata & KEEP;
    end

    for (genvar g = 0; g < NCLS; g++) begin : g_en
        assign trap_en[g] = cw_q[en_pos(g)];
    end
endmodule

// File: rtl/fpx_event_shape.sv
module fpx_event_shape
    import fpx_pkg::*;
(
    input  logic            valid,
    input  logic [NCLS-1:0] raw,
    input  logic            flushed,
    input  logic            alt,
    input  logic            in_flush,
    input  logic            nan_other,
    input  logic            denorm_in,
    output logic [NCLS-1:0] ev
);
    logic idn_alt;

    always_comb begin
        idn_alt = denorm_in && !in_flush && !nan_other && !raw[C_INV] && !raw[C_DZ];
        ev        = raw;
        ev[C_INX] = raw[C_INX] | (alt & flushed);
        ev[C_IDN] = alt ? idn_alt : raw[C_IDN];
        if (!valid) ev = '0;
    end
endmodule

// File: rtl/fpx_flag_trap.sv
module fpx_flag_trap
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] ev,
    input  logic            ftz,
    input  logic [NCLS-1:0] trap_en,
    input  logic            st_we,
    input  logic [NCLS-1:0] st_wdata,
    output logic [NCLS-1:0] flags,
    output logic            trap_req,
    output logic [NCLS-1:0] trap_cause
);
    trap_st_e        state_q, state_d;
    logic [NCLS-1:0] trapped, setv, pick, cause_q;

    always_comb begin
        trapped = ev & trap_en;
        if (ftz) trapped[C_UNF] = 1'b0;
        setv = ev & ~trapped;
        pick = '0;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (trapped[i]) pick = NCLS'(1) << i;
        end
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: if (|trapped) state_d = ST_TRAP;
            ST_TRAP: if (|trapped) state_d = ST_TRAP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            cause_q <= '0;
        end else begin
            flags <= (st_we ? st_wdata : flags) | setv;
            if (|trapped) cause_q <= pick;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_TRAP: begin trap_req = 1'b1; trap_cause = cause_q; end
            default: begin trap_req = 1'b0; trap_cause = '0;      end
        endcase
    end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
    import fpx_pkg::*;
#(
    parameter logic [5:0] TRAP_SUPPORT = 6'b111111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cw_we,
    input  logic [63:0] cw_wdata,
    output logic [63:0] cw_rdata,
    input  logic        st_we,
    input  logic [5:0]  st_wdata,
    output logic [5:0]  st_rdata,
    input  logic        ev_valid,
    input  logic [5:0]  ev_raw,
    input  logic        ctx_ftz,
    input  logic        ctx_flushed,
    input  logic        ctx_alt,
    input  logic        ctx_in_flush,
    input  logic        ctx_nan_other,
    input  logic        ctx_denorm_in,
    output logic        trap_req,
    output logic [5:0]  trap_cause
);
    logic [NCLS-1:0] trap_en, ev_eff;

    fpx_ctrl_reg #(.TRAP_SUPPORT(TRAP_SUPPORT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(cw_we), .wdata(cw_wdata),
        .cw_q(cw_rdata), .trap_en(trap_en)
    );

    fpx_event_shape u_shape (
        .valid(ev_valid), .raw(ev_raw), .flushed(ctx_flushed), .alt(ctx_alt),
        .in_flush(ctx_in_flush), .nan_other(ctx_nan_other),
        .denorm_in(ctx_denorm_in), .ev(ev_eff)
    );

    fpx_flag_trap u_flag (
        .clk(clk), .rst_n(rst_n), .ev(ev_eff), .ftz(ctx_ftz), .trap_en(trap_en),
        .st_we(st_we), .st_wdata(st_wdata), .flags(st_rdata),
        .trap_req(trap_req), .trap_cause(trap_cause)
    );
endmodule

// File: rtl/fpx_trap_unit_chk.sv
module fpx_trap_unit_chk
    import fpx_pkg::*;
#(
    parameter logic [5:0] TRAP_SUPPORT = 6'b111111
) (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] cw_rdata,
    input logic        st_we,
    input logic [5:0]  st_rdata,
    input logic        ev_valid,
    input logic [5:0]  ev_raw,
    input logic        ctx_ftz,
    input logic        trap_req,
    input logic [5:0]  trap_cause
);
    localparam logic [63:0] UNSUP_EN = en_mask(~TRAP_SUPPORT);

    // R5
    trap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(trap_cause) == 1));
    // R5
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_cause == 6'd0));
    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> (($past(st_rdata) & ~st_rdata) == 6'd0));
    // R10
    trap_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(ev_valid));
    // R3
    unsup_en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_rdata & UNSUP_EN) == 64'd0);
    // R7
    ftz_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ctx_ftz && ev_raw[C_UNF]) |=> st_rdata[C_UNF]);
endmodule

bind fpx_trap_unit fpx_trap_unit_chk #(.TRAP_SUPPORT(TRAP_SUPPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cw_rdata(cw_rdata), .st_we(st_we),
    .st_rdata(st_rdata), .ev_valid(ev_valid), .ev_raw(ev_raw),
    .ctx_ftz(ctx_ftz), .trap_req(trap_req), .trap_cause(trap_cause)
);

// File: tb/fpx_trap_unit_bench.sv
`timescale 1ns/1ps
module fpx_trap_unit_bench;
    localparam logic [5:0] SUP = 6'b101111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_we = 0, st_we = 0, ev_valid = 0;
    logic [63:0] cw_wdata = '0, cw_rdata;
    logic [5:0]  st_wdata = '0, st_rdata, ev_raw = '0, trap_cause;
    logic        ctx_ftz = 0, ctx_flushed = 0, ctx_alt = 0, ctx_in_flush = 0;
    logic        ctx_nan_other = 0, ctx_denorm_in = 0, trap_req;

    int    errors = 0, checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    logic [63:0] m_cw = '0;
    logic [5:0]  m_flags = '0, m_cause = '0;
    logic        m_trap = 0;
    int          epos [6] = '{8, 9, 10, 11, 12, 15};

    fpx_trap_unit #(.TRAP_SUPPORT(SUP)) u_fpx_trap_unit (
        .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .cw_wdata(cw_wdata),
        .cw_rdata(cw_rdata), .st_we(st_we), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .ev_valid(ev_valid), .ev_raw(ev_raw),
        .ctx_ftz(ctx_ftz), .ctx_flushed(ctx_flushed), .ctx_alt(ctx_alt),
        .ctx_in_flush(ctx_in_flush), .ctx_nan_other(ctx_nan_other),
        .ctx_denorm_in(ctx_denorm_in), .trap_req(trap_req), .trap_cause(trap_cause)
    );

    always #10 clk = ~clk;

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Reference model: next state from current inputs
    task automatic model_step();
        logic [5:0]  ev, nf;
        logic [63:0] keep;
        logic        tr;
        logic [5:0]  cs;
        ev = '0;
        if (ev_valid) begin
            ev = ev_raw;
            if (ctx_alt && ctx_flushed) ev[4] = 1'b1;
            if (ctx_alt)
                ev[5] = ctx_denorm_in && !ctx_in_flush && !ctx_nan_other
                        && !ev_raw[0] && !ev_raw[1];
        end
        nf = st_we ? st_wdata : m_flags;
        tr = 0; cs = '0;
        for (int c = 0; c < 6; c++) begin
            if (ev[c]) begin
                if (m_cw[epos[c]] && !(c == 3 && ctx_ftz)) begin
                    if (!tr) begin tr = 1; cs[c] = 1'b1; end
                end else nf[c] = 1'b1;
            end
        end
        keep = 64'h07FF_0007;
        for (int c = 0; c < 6; c++) if (SUP[c]) keep[epos[c]] = 1'b1;
        if (cw_we) m_cw = cw_wdata & keep;
        m_flags = nf; m_trap = tr; m_cause = cs;
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        check("cw_rdata", cw_rdata, m_cw);
        check("st_rdata", {58'd0, st_rdata}, {58'd0, m_flags});
        check("trap_req", {63'd0, trap_req}, {63'd0, m_trap});
        check("trap_cause", {58'd0, trap_cause}, {58'd0, m_cause});
        cw_we = 0; st_we = 0; ev_valid = 0; ev_raw = '0;
        ctx_ftz = 0; ctx_flushed = 0; ctx_alt = 0; ctx_in_flush = 0;
        ctx_nan_other = 0; ctx_denorm_in = 0;
    endtask

    task automatic wr_cw(logic [63:0] d);
        cw_we = 1; cw_wdata = d; cyc();
    endtask

    task automatic wr_st(logic [5:0] d);
        st_we = 1; st_wdata = d; cyc();
    endtask

    task automatic fire(logic [5:0] raw);
        ev_valid = 1; ev_raw = raw;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1"; cyc(); cyc();
        // R2 stored fields; R3 unsupported inexact enable reads zero
        cur_req = "R2"; wr_cw('1); cyc();
        cur_req = "R3"; wr_cw(64'h0000_0000_0000_1000); cyc();
        fire(6'b010000); cyc(); cyc();
        wr_st(6'd0); wr_cw(64'd0);
        // R4 untrapped events set sticky flags
        cur_req = "R4";
        for (int c = 0; c < 6; c++) begin fire(6'd1 << c); cyc(); end
        cyc();
        // R11 status write replaces, same-cycle event ORed on top
        cur_req = "R11"; wr_st(6'b000101);
        st_we = 1; st_wdata = 6'b100000; fire(6'b000010); cyc(); cyc();
        wr_st(6'd0);
        // R5 trapped event: flag unchanged, one-cycle pulse, back-to-back
        cur_req = "R5"; wr_cw(64'h0000_0000_0000_9F00);
        fire(6'b000001); cyc(); cyc();
        fire(6'b000100); cyc(); fire(6'b100000); cyc(); cyc(); cyc();
        // R6 priority among trapped classes, untrapped still flag
        cur_req = "R6"; wr_cw(64'h0000_0000_0000_0C00);
        fire(6'b011101); cyc(); cyc();
        wr_st(6'd0);
        // R7 underflow under flush-to-zero never traps
        cur_req = "R7"; fire(6'b001000); ctx_ftz = 1; cyc(); cyc();
        fire(6'b001000); cyc(); cyc();
        wr_st(6'd0); wr_cw(64'd0);
        // R8 inexact from flushing
        cur_req = "R8"; fire(6'd0); ctx_flushed = 1; cyc(); cyc();
        fire(6'd0); ctx_flushed = 1; ctx_alt = 1; cyc(); cyc();
        wr_st(6'd0);
        // R9 input-denormal rules
        cur_req = "R9";
        fire(6'd0); ctx_alt = 1; ctx_denorm_in = 1; ctx_nan_other = 1; cyc();
        fire(6'd0); ctx_alt = 1; ctx_denorm_in = 1; ctx_in_flush = 1; cyc();
        fire(6'b000001); ctx_alt = 1; ctx_denorm_in = 1; cyc();
        fire(6'b000010); ctx_alt = 1; ctx_denorm_in = 1; cyc();
        fire(6'b100000); ctx_alt = 1; cyc();
        fire(6'd0); ctx_denorm_in = 1; cyc(); cyc();
        fire(6'd0); ctx_alt = 1; ctx_denorm_in = 1; cyc(); cyc();
        wr_st(6'd0); wr_cw(64'h0000_0000_0000_8000);
        fire(6'd0); ctx_alt = 1; ctx_denorm_in = 1; cyc(); cyc();
        fire(6'b100000); cyc(); cyc();
        // R10 nothing happens without ev_valid
        cur_req = "R10"; wr_cw(64'h0000_0000_0000_9F00); wr_st(6'd0);
        ev_raw = '1; ctx_alt = 1; ctx_flushed = 1; ctx_denorm_in = 1; cyc(); cyc();
        // R12 event judged against enables before the write
        cur_req = "R12"; wr_cw(64'd0);
        cw_we = 1; cw_wdata = 64'h0000_0000_0000_0100; fire(6'b000001); cyc();
        cyc(); fire(6'b000001); cyc(); cyc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule